// File: doc/BRIEF.md
# Aspect-Configurable Dual-Clock SRAM

This block is a 256-bit storage array with a write port and a read port. Each port has its own clock, and the two clocks are unrelated. A static organisation input selects how the same storage is seen. In one setting it is 32 words of 8 bits. In the other it is 64 words of 4 bits. Both ports always carry a 6-bit address and 8-bit data lanes. The organisation only changes how the address is decoded and which data lanes take part.

Each port has a static polarity input that selects whether that port acts on the rising or the falling edge of its clock. The storage is built as parallel nibble lanes, so a 4-bit write changes one lane and leaves the other untouched, with no read-modify-write. Reads are registered behind a read enable.

Top module: `dual_aspect_sram`

## Requirements
- R1: With `mode_wide`=1 (32x8), a write with both enables high on the active write edge stores `wr_data[7:0]` at word `wr_addr[4:0]`. A later read of word `rd_addr[4:0]` returns that byte on `rd_data`.
- R2: With `mode_wide`=1, address bit 5 of both ports has no effect. Addresses `a` and `a+32` name the same word.
- R3: With `mode_wide`=0 (64x4), a write stores `wr_data[3:0]` into byte `wr_addr[5:1]`. When `wr_addr[0]`=0 it goes into bits [3:0] of that byte; when `wr_addr[0]`=1 it goes into bits [7:4]. The other nibble of the byte is unchanged, and `wr_data[7:4]` is ignored.
- R4: With `mode_wide`=0, a read returns the nibble selected by `rd_addr[5:1]`/`rd_addr[0]` on `rd_data[3:0]`, and `rd_data[7:4]` is 0.
- R5: The array is written only on an active write edge at which `wr_en` and `wr_blk_en` are both 1. With either one low, the contents do not change.
- R6: On an active read edge with `rd_en`=1, `rd_data` takes the addressed value, one edge after the inputs are presented. With `rd_en`=0, `rd_data` holds, whatever `rd_addr` does.
- R7: Each port's polarity input selects its active edge: 0 for the rising edge, 1 for the falling edge. The two ports are set independently.
- R8: When a read and a write of the same location fall on the same clock edge, the read returns the contents from before the write.
- R9: While `rst_n` is low, `rd_data` is 0. Reset release is synchronised in each clock domain. The array contents survive reset.
- R10: Both organisations share one store. Byte `k` written as 32x8 reads back as nibbles `2k` (bits [3:0]) and `2k+1` (bits [7:4]) as 64x4, and the reverse holds too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| mode_wide | input | 1 | Organisation: 1 = 32x8, 0 = 64x4 |
| wr_clk | input | 1 | Write port clock |
| wr_clk_fall | input | 1 | Write active edge: 0 rising, 1 falling |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write enable |
| wr_blk_en | input | 1 | Block enable, qualifies writes |
| rd_clk | input | 1 | Read port clock |
| rd_clk_fall | input | 1 | Read active edge: 0 rising, 1 falling |
| rd_addr | input | 6 | Read address |
| rd_en | input | 1 | Read enable |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: 4-bit lanes, 2 lanes and 32 rows. At that size every one of the 64 addresses can be swept in both organisations, including the aliased upper half in the 32x8 setting. A byte model in the bench predicts every readback by arithmetic, including across-mode views of the same store. Tying both port clocks to one source lets it place a read and a write on exactly the same edge. Switching the polarity inputs between resets reaches the mixed-edge cases.

// File: rtl/sram_aspect_pkg.sv
package sram_aspect_pkg;

  // Organisation of the shared store as seen by both ports.
  typedef enum logic {
    ORG_NARROW = 1'b0,
    ORG_WIDE   = 1'b1
  } org_e;

endpackage

// File: rtl/sram_reset_sync.sv
module sram_reset_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  // Assert at once, release after two edges of the local clock.
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_aspect_pkg::*;
#(
  parameter int NARROW_W = 4,
  parameter int LANES    = 2,
  parameter int ROW_W    = 5,
  parameter int LANE_W   = 1,
  parameter int ADDR_W   = 6,
  parameter int WORD_W   = 8
) (
  input  logic              mode_wide,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              wr_blk_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] lane_wd
);

  org_e org;
  logic write_ok;

  always_comb begin
    org      = org_e'(mode_wide);
    write_ok = wr_en & wr_blk_en;
    wr_row   = '0;
    lane_we  = '0;
    lane_wd  = '0;
    if (org == ORG_WIDE) begin
      // Upper address bit is not part of the word index here.
      wr_row  = wr_addr[ROW_W-1:0];
      lane_we = {LANES{write_ok}};
      lane_wd = wr_data;
    end else begin
      wr_row = wr_addr[ADDR_W-1 -: ROW_W];
      for (int l = 0; l < LANES; l++) begin
        lane_we[l] = write_ok && (wr_addr[LANE_W-1:0] == LANE_W'(l));
        lane_wd[l*NARROW_W +: NARROW_W] = wr_data[NARROW_W-1:0];
      end
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int NARROW_W = 4,
  parameter int LANES    = 2,
  parameter int ROWS     = 32,
  parameter int ROW_W    = 5,
  parameter int WORD_W   = 8
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [LANES-1:0]  lane_we,
  input  logic [WORD_W-1:0] lane_wd,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_row_data
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NARROW_W-1:0] mem [ROWS];

    // Storage carries no reset; each lane has its own write enable.
    always_ff @(posedge wclk) begin
      if (lane_we[l]) begin
        mem[wr_row] <= lane_wd[l*NARROW_W +: NARROW_W];
      end
    end

    assign rd_row_data[l*NARROW_W +: NARROW_W] = mem[rd_row];

    assert_lane_store_R1: assert property (@(posedge wclk) disable iff (!wrst_n)
      lane_we[l] |=> (mem[$past(wr_row)] == $past(lane_wd[l*NARROW_W +: NARROW_W])));
  end

endmodule

// File: rtl/sram_rd_port.sv
module sram_rd_port
  import sram_aspect_pkg::*;
#(
  parameter int NARROW_W = 4,
  parameter int ROW_W    = 5,
  parameter int LANE_W   = 1,
  parameter int ADDR_W   = 6,
  parameter int WORD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_row_data,
  output logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_data
);

  org_e              org;
  logic [LANE_W-1:0] lane_sel;
  logic [WORD_W-1:0] fmt_data;
  logic [WORD_W-1:0] data_d;
  logic [WORD_W-1:0] data_q;

  always_comb begin
    org      = org_e'(mode_wide);
    lane_sel = rd_addr[LANE_W-1:0];
    fmt_data = '0;
    if (org == ORG_WIDE) begin
      rd_row   = rd_addr[ROW_W-1:0];
      fmt_data = rd_row_data;
    end else begin
      rd_row = rd_addr[ADDR_W-1 -: ROW_W];
      fmt_data[NARROW_W-1:0] = rd_row_data[int'(lane_sel)*NARROW_W +: NARROW_W];
    end
    // Clock enable: hold when the read is not requested.
    data_d = rd_en ? fmt_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign rd_data = data_q;

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mode_wide) |=> (rd_data[WORD_W-1:NARROW_W] == '0));

endmodule

// File: rtl/dual_aspect_sram.sv
module dual_aspect_sram #(
  parameter int   NARROW_W = 4,
  parameter int   LANES    = 2,
  parameter int   ROWS     = 32,
  localparam int  ROW_W    = $clog2(ROWS),
  localparam int  LANE_W   = $clog2(LANES),
  localparam int  ADDR_W   = ROW_W + LANE_W,
  localparam int  WORD_W   = NARROW_W * LANES
) (
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              wr_clk,
  input  logic              wr_clk_fall,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              wr_blk_en,
  input  logic              rd_clk,
  input  logic              rd_clk_fall,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data
);

  // Active edge per port: a static inversion ahead of every flop.
  logic wclk_eff;
  logic rclk_eff;
  assign wclk_eff = wr_clk ^ wr_clk_fall;
  assign rclk_eff = rd_clk ^ rd_clk_fall;

  logic wrst_n;
  logic rrst_n;

  sram_reset_sync u_wr_rst (.clk(wclk_eff), .rst_n_in(rst_n), .rst_n_out(wrst_n));
  sram_reset_sync u_rd_rst (.clk(rclk_eff), .rst_n_in(rst_n), .rst_n_out(rrst_n));

  logic [ROW_W-1:0]  wr_row;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] lane_wd;
  logic [ROW_W-1:0]  rd_row;
  logic [WORD_W-1:0] rd_row_data;

  sram_wr_decode #(
    .NARROW_W(NARROW_W), .LANES(LANES), .ROW_W(ROW_W),
    .LANE_W(LANE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_wr_decode (
    .mode_wide(mode_wide), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_en(wr_en), .wr_blk_en(wr_blk_en),
    .wr_row(wr_row), .lane_we(lane_we), .lane_wd(lane_wd)
  );

  sram_lane_array #(
    .NARROW_W(NARROW_W), .LANES(LANES), .ROWS(ROWS),
    .ROW_W(ROW_W), .WORD_W(WORD_W)
  ) u_array (
    .wclk(wclk_eff), .wrst_n(wrst_n), .wr_row(wr_row), .lane_we(lane_we),
    .lane_wd(lane_wd), .rd_row(rd_row), .rd_row_data(rd_row_data)
  );

  sram_rd_port #(
    .NARROW_W(NARROW_W), .ROW_W(ROW_W), .LANE_W(LANE_W),
    .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_rd_port (
    .clk(rclk_eff), .rst_n(rrst_n), .mode_wide(mode_wide), .rd_addr(rd_addr),
    .rd_en(rd_en), .rd_row_data(rd_row_data), .rd_row(rd_row), .rd_data(rd_data)
  );

  assert_gated_write_R5: assert property (@(posedge wclk_eff) disable iff (!wrst_n)
    !(wr_en && wr_blk_en) |-> (lane_we == '0));

  assert_single_nibble_R3: assert property (@(posedge wclk_eff) disable iff (!wrst_n)
    !mode_wide |-> $onehot0(lane_we));

  assert_full_word_R1: assert property (@(posedge wclk_eff) disable iff (!wrst_n)
    (mode_wide && wr_en && wr_blk_en) |-> (lane_we == {LANES{1'b1}}));

endmodule

// File: tb/dual_aspect_sram_bench.sv
`timescale 1ns/1ps
module dual_aspect_sram_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, mode_wide;
  logic       wr_fall, rd_fall;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       wr_en, wr_blk_en, rd_en;

  dual_aspect_sram u_dual_aspect_sram (
    .rst_n(rst_n), .mode_wide(mode_wide),
    .wr_clk(clk), .wr_clk_fall(wr_fall), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_en(wr_en), .wr_blk_en(wr_blk_en),
    .rd_clk(clk), .rd_clk_fall(rd_fall), .rd_addr(rd_addr), .rd_en(rd_en),
    .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model [32];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_edge();
    if (wr_fall) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  task automatic rd_edge();
    if (rd_fall) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] expect_rd(input logic [5:0] a);
    if (mode_wide) return model[a[4:0]];
    return a[0] ? {4'h0, model[a[5:1]][7:4]} : {4'h0, model[a[5:1]][3:0]};
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    if (mode_wide) model[a[4:0]] = d;
    else if (a[0]) model[a[5:1]][7:4] = d[3:0];
    else model[a[5:1]][3:0] = d[3:0];
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1; wr_blk_en = 1'b1;
    wr_edge();
    wr_en = 1'b0; wr_blk_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] v);
    rd_addr = a; rd_en = 1'b1;
    rd_edge();
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic apply_reset(input logic wf, input logic rf);
    rst_n = 1'b0;
    #1;
    wr_fall = wf; rd_fall = rf;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] old;
    rst_n = 1'b0; mode_wide = 1'b1; wr_fall = 1'b0; rd_fall = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0; wr_en = 1'b0; wr_blk_en = 1'b0; rd_en = 1'b0;
    apply_reset(1'b0, 1'b0);
    check("R9 reset read data", rd_data, 8'h00);

    // R1/R2: fill all 32 bytes, half of them through the aliased upper addresses
    for (int a = 0; a < 32; a++) begin
      do_write(6'(a + ((a % 2) * 32)), 8'(a * 37 + 11));
    end
    for (int a = 0; a < 64; a++) begin
      do_read(6'(a), v);
      check(a < 32 ? "R1 byte readback" : "R2 bit5 ignored", v, expect_rd(6'(a)));
    end

    // R5: writes with one enable low change nothing
    wr_addr = 6'd5; wr_data = ~model[5]; wr_en = 1'b1; wr_blk_en = 1'b0; wr_edge();
    wr_addr = 6'd6; wr_data = ~model[6]; wr_en = 1'b0; wr_blk_en = 1'b1; wr_edge();
    wr_en = 1'b0; wr_blk_en = 1'b0;
    do_read(6'd5, v); check("R5 blk_en low", v, model[5]);
    do_read(6'd6, v); check("R5 wr_en low", v, model[6]);

    // R6: read data holds while rd_en is low
    do_read(6'd7, v);
    check("R6 read one edge later", v, model[7]);
    rd_addr = 6'd8; rd_edge(); rd_addr = 6'd9; rd_edge();
    check("R6 hold with rd_en low", rd_data, model[7]);

    // R8: read and write of one location on the same edge
    old = model[9];
    rd_addr = 6'd9; rd_en = 1'b1;
    wr_addr = 6'd9; wr_data = old ^ 8'hA5; wr_en = 1'b1; wr_blk_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0; wr_blk_en = 1'b0;
    check("R8 same-edge read gives old", rd_data, old);
    model[9] = old ^ 8'hA5;
    do_read(6'd9, v); check("R8 new value after", v, model[9]);

    // R10/R4: narrow view of the byte contents
    mode_wide = 1'b0;
    for (int a = 0; a < 64; a++) begin
      do_read(6'(a), v);
      check("R10 R4 nibble view", v, expect_rd(6'(a)));
    end

    // R3: nibble writes with junk in the upper data bits
    for (int a = 0; a < 64; a += 3) begin
      do_write(6'(a), {4'hF, 4'(a) ^ 4'h6});
    end
    for (int a = 0; a < 64; a++) begin
      do_read(6'(a), v);
      check("R3 nibble write and neighbour", v, expect_rd(6'(a)));
    end
    mode_wide = 1'b1;
    for (int a = 0; a < 32; a++) begin
      do_read(6'(a), v);
      check("R10 byte view after nibble writes", v, expect_rd(6'(a)));
    end

    // R7/R9: falling-edge write port, rising-edge read port, contents kept
    apply_reset(1'b1, 1'b0);
    check("R9 reset clears read data", rd_data, 8'h00);
    do_read(6'd3, v); check("R9 array survives reset", v, model[3]);
    do_write(6'd12, 8'h3C);
    do_read(6'd12, v); check("R7 falling write edge", v, 8'h3C);

    // R7: falling-edge read port
    apply_reset(1'b0, 1'b1);
    @(negedge clk); #1;
    rd_addr = 6'd12; rd_en = 1'b1;
    @(posedge clk); #1;
    check("R7 rising edge inactive for read", rd_data, 8'h00);
    @(negedge clk); #1;
    rd_en = 1'b0;
    check("R7 falling read edge", rd_data, 8'h3C);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule